// File: doc/BRIEF.md
# MMIO Region Decoder with Access Checks

This block sits between a simple memory-mapped request port and a group of register regions. Each request carries an address, a read/write flag, an access size of 1, 2, 4 or 8 bytes, and little-endian write data. The block subtracts a fixed base address from the request address. It then searches a parameter table of regions for the one whose range contains the resulting offset. Each table entry holds a start offset, a length and the set of access widths the region accepts.

The search is combinational. Its result, together with a width and alignment check against the selected region's permissions, is registered. One cycle after the request, an accepted access appears on the handler port with the region index and the offset within that region. A rejected or unmapped access never reaches a handler. Such a read returns zero data and such a write is dropped. No error is ever signalled. Every request gets a response one cycle later, and the response carries a flag that says whether the access was forwarded.

Top module: `mmio_region_decoder`

## Requirements
- R1: The offset is the request address minus BASE (modulo 2^AW). A region matches when start <= offset < start + length. When several regions match, the one with the lowest table index is chosen, and the handler port shows its index and the value offset minus that region's start.
- R2: An offset that matches no region is unmapped and is never forwarded.
- R3: Size code 0 (1 byte) is forwarded only if the region's permission bit 0 (8-bit) is set.
- R4: Size code 2 (4 bytes) is forwarded only if the region's permission bit 1 (32-bit) is set and address bits 1:0 are zero.
- R5: Size code 3 (8 bytes) is forwarded only if the region's permission bit 2 (64-bit) is set and address bits 2:0 are zero.
- R6: Size code 1 (2 bytes) is always rejected, whatever the region's permissions.
- R7: A rejected or unmapped read responds with all-zero data. A rejected or unmapped write raises no handler strobe.
- R8: For an accepted access, hdl_valid is high exactly one cycle after the request. In that cycle the handler port carries the write flag, size, region index, region-relative offset and write data unchanged.
- R9: The read data of an accepted read is the handler data with every byte at or above the access length forced to zero. Byte 0 (the lowest address) sits in bits 7:0.
- R10: rsp_valid is high exactly in the cycle after each request and low otherwise. rsp_fwd tells whether that access was forwarded. Reset clears both response and handler strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Size code: 0=1B, 1=2B, 2=4B, 3=8B |
| req_addr | input | AW | Byte address |
| req_wdata | input | 64 | Little-endian write data |
| hdl_valid | output | 1 | Forwarded access strobe to handlers |
| hdl_write | output | 1 | Forwarded write flag |
| hdl_region | output | IDXW | Index of selected region |
| hdl_offset | output | AW | Offset relative to region start |
| hdl_size | output | 2 | Forwarded size code |
| hdl_wdata | output | 64 | Forwarded write data |
| hdl_rdata | input | 64 | Handler read data, valid while hdl_valid |
| rsp_valid | output | 1 | Response strobe, one cycle after request |
| rsp_write | output | 1 | Write flag of the answered request |
| rsp_fwd | output | 1 | 1 if the access reached a handler |
| rsp_rdata | output | 64 | Read data (zero when not forwarded) |

## Verification
Every byte address from a few bytes below the base to past the last region is issued with all four size codes, both as a read and as a write. This crosses region edges, gaps, below-base wraparound and every alignment. Unaligned 4- and 8-byte accesses inside permitting regions separate the alignment checks from the permission checks. Regions that allow only 32-bit or only 64-bit access separate the width rules from each other. The 2-byte accesses show that no permission set admits them. The handler read data depends on the offset, so a wrong region offset or a wrong lane mask shows up in the returned bytes.

// File: rtl/mmio_dec_pkg.sv
package mmio_dec_pkg;
  typedef enum logic [1:0] {
    SZ_B1 = 2'd0,
    SZ_B2 = 2'd1,
    SZ_B4 = 2'd2,
    SZ_B8 = 2'd3
  } acc_size_e;

  localparam int PERM_W  = 3;
  localparam int PERM_8  = 0;
  localparam int PERM_32 = 1;
  localparam int PERM_64 = 2;

  // byte lanes covered by an access of the given size, byte 0 in bits 7:0
  function automatic logic [63:0] lane_mask(acc_size_e s);
    case (s)
      SZ_B1:   return 64'h0000_0000_0000_00FF;
      SZ_B2:   return 64'h0000_0000_0000_FFFF;
      SZ_B4:   return 64'h0000_0000_FFFF_FFFF;
      default: return 64'hFFFF_FFFF_FFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/mmio_region_match.sv
module mmio_region_match #(
  parameter int AW   = 16,
  parameter int NREG = 4,
  parameter int IDXW = 2,
  parameter logic [NREG-1:0][AW-1:0] STARTS = '0,
  parameter logic [NREG-1:0][AW-1:0] LENS   = '0
) (
  input  logic [AW-1:0]   off,
  output logic            hit,
  output logic [IDXW-1:0] idx
);
  logic [NREG-1:0] in_rng;

  // one comparator pair per region, one bit wider to avoid end wrap
  generate
    for (genvar g = 0; g < NREG; g++) begin : g_cmp
      logic [AW:0] lo, hi;
      assign lo = {1'b0, STARTS[g]};
      assign hi = {1'b0, STARTS[g]} + {1'b0, LENS[g]};
      assign in_rng[g] = ({1'b0, off} >= lo) && ({1'b0, off} < hi);
    end
  endgenerate

  // lowest index wins
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (in_rng[i]) begin
        hit = 1'b1;
        idx = i[IDXW-1:0];
      end
    end
  end
endmodule

// File: rtl/mmio_access_check.sv
module mmio_access_check
  import mmio_dec_pkg::*;
(
  input  logic [PERM_W-1:0] perm,
  input  acc_size_e         size,
  input  logic [2:0]        addr_lo,
  output logic              ok
);
  always_comb begin
    case (size)
      SZ_B1:   ok = perm[PERM_8];
      SZ_B4:   ok = perm[PERM_32] && (addr_lo[1:0] == 2'b00);
      SZ_B8:   ok = perm[PERM_64] && (addr_lo == 3'b000);
      default: ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/mmio_region_decoder.sv
module mmio_region_decoder
  import mmio_dec_pkg::*;
#(
  parameter int AW   = 16,
  parameter int NREG = 4,
  parameter int IDXW = (NREG > 1) ? $clog2(NREG) : 1,
  parameter logic [AW-1:0] BASE = 16'h1000,
  parameter logic [NREG-1:0][AW-1:0] REG_START =
    {16'h0080, 16'h0040, 16'h0010, 16'h0000},
  parameter logic [NREG-1:0][AW-1:0] REG_LEN =
    {16'h0008, 16'h0020, 16'h0010, 16'h0010},
  parameter logic [NREG-1:0][2:0] REG_PERM =
    {3'b100, 3'b111, 3'b011, 3'b010}
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [1:0]      req_size,
  input  logic [AW-1:0]   req_addr,
  input  logic [63:0]     req_wdata,
  output logic            hdl_valid,
  output logic            hdl_write,
  output logic [IDXW-1:0] hdl_region,
  output logic [AW-1:0]   hdl_offset,
  output logic [1:0]      hdl_size,
  output logic [63:0]     hdl_wdata,
  input  logic [63:0]     hdl_rdata,
  output logic            rsp_valid,
  output logic            rsp_write,
  output logic            rsp_fwd,
  output logic [63:0]     rsp_rdata
);
  typedef struct packed {
    logic            v;
    logic            wr;
    logic            fwd;
    logic [IDXW-1:0] idx;
    logic [AW-1:0]   rel;
    acc_size_e       size;
    logic [63:0]     wdata;
  } stage_t;

  logic [AW-1:0]     off;
  logic              hit;
  logic [IDXW-1:0]   idx;
  logic              size_ok;
  logic [PERM_W-1:0] sel_perm;
  acc_size_e         size_in;
  stage_t            st;

  assign off     = req_addr - BASE;
  assign size_in = acc_size_e'(req_size);

  mmio_region_match #(
    .AW(AW), .NREG(NREG), .IDXW(IDXW),
    .STARTS(REG_START), .LENS(REG_LEN)
  ) u_match (
    .off(off), .hit(hit), .idx(idx)
  );

  always_comb begin
    sel_perm = '0;
    for (int i = 0; i < NREG; i++) begin
      if (idx == i[IDXW-1:0]) sel_perm = REG_PERM[i];
    end
  end

  mmio_access_check u_chk_acc (
    .perm(sel_perm), .size(size_in), .addr_lo(req_addr[2:0]), .ok(size_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= '0;
    end else begin
      st.v     <= req_valid;
      st.wr    <= req_write;
      st.fwd   <= req_valid && hit && size_ok;
      st.idx   <= idx;
      st.rel   <= off - REG_START[idx];
      st.size  <= size_in;
      st.wdata <= req_wdata;
    end
  end

  assign hdl_valid  = st.v && st.fwd;
  assign hdl_write  = st.wr;
  assign hdl_region = st.idx;
  assign hdl_offset = st.rel;
  assign hdl_size   = st.size;
  assign hdl_wdata  = st.wdata;

  assign rsp_valid = st.v;
  assign rsp_write = st.wr;
  assign rsp_fwd   = st.v && st.fwd;
  assign rsp_rdata = (st.v && st.fwd && !st.wr) ? (hdl_rdata & lane_mask(st.size)) : 64'd0;
endmodule

// File: rtl/mmio_region_decoder_chk.sv
module mmio_region_decoder_chk (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic [1:0]  req_size,
  input logic        hdl_valid,
  input logic        hdl_write,
  input logic [1:0]  hdl_size,
  input logic        rsp_valid,
  input logic        rsp_write,
  input logic        rsp_fwd,
  input logic [63:0] rsp_rdata
);
  // R10
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  // R10
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  // R6
  half_word_reject_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_size == 2'd1) |=> !hdl_valid);
  // R7
  reject_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_fwd && !rsp_write) |-> (rsp_rdata == 64'd0));
  // R8
  strobe_matches_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    hdl_valid |-> (rsp_valid && rsp_fwd));
  // R9
  byte_read_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (hdl_valid && !hdl_write && hdl_size == 2'd0) |-> (rsp_rdata[63:8] == 56'd0));
endmodule

bind mmio_region_decoder mmio_region_decoder_chk u_assert (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_size(req_size),
  .hdl_valid(hdl_valid), .hdl_write(hdl_write), .hdl_size(hdl_size),
  .rsp_valid(rsp_valid), .rsp_write(rsp_write), .rsp_fwd(rsp_fwd),
  .rsp_rdata(rsp_rdata)
);

// File: tb/sim_mmio_region_decoder.sv
module sim_mmio_region_decoder;
  localparam int AW = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [15:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic        hdl_valid, hdl_write, rsp_valid, rsp_write, rsp_fwd;
  logic [1:0]  hdl_region, hdl_size;
  logic [15:0] hdl_offset;
  logic [63:0] hdl_wdata, hdl_rdata, rsp_rdata;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  // handler model: data depends on region-relative offset
  assign hdl_rdata = {8{hdl_offset[7:0]}} ^ 64'h0123_4567_89AB_CDEF;

  mmio_region_decoder u0 (.*);

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // independent table: start, length, permission {64,32,8}
  function automatic void model(input logic [15:0] addr, input int sz,
                                output bit fwd, output int ridx, output logic [15:0] rel,
                                output string tag);
    logic [15:0] st [4] = '{16'h0000, 16'h0010, 16'h0040, 16'h0080};
    int          ln [4] = '{16, 16, 32, 8};
    logic [2:0]  pm [4] = '{3'b010, 3'b011, 3'b111, 3'b100};
    logic [15:0] off = addr - 16'h1000;
    bit hit = 0;
    ridx = 0; rel = '0;
    for (int i = 3; i >= 0; i--)
      if (int'(off) >= int'(st[i]) && int'(off) < int'(st[i]) + ln[i]) begin
        hit = 1; ridx = i; rel = off - st[i];
      end
    fwd = 0;
    if (!hit) tag = "R2";
    else case (sz)
      0: begin tag = "R3"; fwd = pm[ridx][0]; end
      1: begin tag = "R6"; fwd = 0; end
      2: begin tag = "R4"; fwd = pm[ridx][1] && addr[1:0] == 2'b00; end
      default: begin tag = "R5"; fwd = pm[ridx][2] && addr[2:0] == 3'b000; end
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(rsp_valid == 0, "R10 reset rsp_valid", 64'(rsp_valid), 0);
    chk(hdl_valid == 0, "R10 reset hdl_valid", 64'(hdl_valid), 0);
    for (int a = 16'h0FF8; a < 16'h1098; a++) begin
      for (int sz = 0; sz < 4; sz++) begin
        for (int w = 0; w < 2; w++) begin
          bit fwd; int ridx; logic [15:0] rel; string tag;
          logic [63:0] mask, expd;
          model(16'(a), sz, fwd, ridx, rel, tag);
          req_valid = 1; req_write = w[0]; req_size = 2'(sz);
          req_addr = 16'(a);
          req_wdata = {16'(a), ~16'(a), 16'(a) ^ 16'h5A5A, ~16'(a)};
          @(negedge clk);
          req_valid = 0;
          chk(rsp_valid == 1, "R10 rsp_valid", 64'(rsp_valid), 1);
          chk(rsp_fwd == fwd, tag, 64'(rsp_fwd), 64'(fwd));
          chk(hdl_valid == fwd, fwd ? "R8 strobe" : "R7 no strobe", 64'(hdl_valid), 64'(fwd));
          if (fwd) begin
            chk(hdl_region == 2'(ridx), "R1 region", 64'(hdl_region), 64'(ridx));
            chk(hdl_offset == rel, "R1 offset", 64'(hdl_offset), 64'(rel));
            chk(hdl_write == w[0] && hdl_size == 2'(sz), "R8 ctrl",
                64'({hdl_write, hdl_size}), 64'({w[0], 2'(sz)}));
            if (w == 1) chk(hdl_wdata == req_wdata, "R8 wdata", hdl_wdata, req_wdata);
          end
          if (w == 0) begin
            mask = (sz == 0) ? 64'hFF : (sz == 3) ? '1 : 64'hFFFF_FFFF;
            expd = fwd ? (({8{rel[7:0]}} ^ 64'h0123_4567_89AB_CDEF) & mask) : 64'd0;
            chk(rsp_rdata == expd, fwd ? "R9 rdata" : "R7 zero", rsp_rdata, expd);
          end
        end
      end
    end
    @(negedge clk);
    chk(rsp_valid == 0, "R10 idle", 64'(rsp_valid), 0);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule